// File: doc/BRIEF.md
# UART Receiver with Flow Control

This block receives asynchronous serial frames on a single input line. Each frame has a start bit, then 7, 8 or 9 data bits sent LSB first, then an optional even or odd parity bit and one stop bit. A divider makes a 16x oversampling tick from the system clock. The receiver confirms each start bit at mid-bit and samples every later bit at its centre. A finished word goes into a receive data register, which the host reads through a small register port.

Each error has its own rule for what happens to the data. On overrun the new word is dropped and the unread word is kept. A parity error or a framing error still stores the word. The three error flags are sticky. A clean frame raises a one-cycle receive-complete pulse. An error raises a one-cycle error pulse, but only when error interrupts are enabled.

An active-low ready-to-send output tells the remote transmitter when to pause. It is low only while the receiver is enabled and no unread word is waiting. Only a read of the low data byte consumes the word. A read of the high byte, which carries bit 8 in 9-bit mode, has no effect on overrun or flow control.

Top module: `uart_rx_fc`

Register map (2-bit address):

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read/write | bit0 receive enable, bit1 error-interrupt enable, bits[3:2] length (00 = 8, 01 = 7, 10 = 9, 11 = 8 data bits), bit4 parity enable, bit5 odd parity (0 = even) |
| 1 | STAT | read/write | bit0 overrun, bit1 parity error, bit2 framing error |
| 2 | DLO | read | data bits [7:0] |
| 3 | DHI | read | bit 8 of the data in result bit 0, all other result bits 0 |

## Requirements
- R1: After reset `rts_no` is 1 and STAT reads 0. Writing CTRL bit0 = 1 drives `rts_no` low in the next cycle when no unread word is held.
- R2: A low pulse on `rx_i` that is high again by the mid-bit check of the start bit (8 ticks) produces no frame and no pulse.
- R3: Data bits are sampled LSB first, and 7, 8 or 9 of them are taken according to CTRL bits[3:2]. DLO returns bits [7:0], and DHI bit 0 returns bit 8. Bits beyond the selected length read as 0.
- R4: With parity enabled, a parity bit that breaks the selected even (bit5 = 0) or odd (bit5 = 1) total sets STAT bit1 and still stores the word.
- R5: A stop bit sampled as 0 sets STAT bit2 and still stores the word.
- R6: A frame that completes while the previous word is unread sets STAT bit0. The held word stays unchanged, and no receive-complete pulse is raised.
- R7: A frame with no error stores the word and raises `rxi_o` for exactly one cycle.
- R8: Any error (overrun, parity, framing) pulses `eri_o` for one cycle if CTRL bit1 is 1, and never if it is 0.
- R9: A read of DLO consumes the word and returns `rts_no` low. A read of DHI changes neither `rts_no` nor the overrun behaviour.
- R10: Error flags are sticky. A write to STAT clears each flag whose write bit is 0 and leaves each flag whose write bit is 1.
- R11: Clearing CTRL bit0 abandons any frame in progress, drives `rts_no` high, and raises no pulse.
- R12: After a word is stored, `rts_no` stays high until the consuming read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rx_i | input | 1 | serial receive line, idle high |
| reg_addr_i | input | 2 | register address |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe (a DLO read consumes the word) |
| reg_wdata_i | input | 6 | register write data |
| reg_rdata_o | output | 8 | register read data for `reg_addr_i` |
| rxi_o | output | 1 | receive-complete pulse |
| eri_o | output | 1 | receive-error pulse |
| rts_no | output | 1 | ready-to-send, active low |

## Verification
The hardest situations to reach are those where events overlap. One is a frame that completes while a word is still unread. Another is a stop bit held low long enough that the receiver's return to idle meets a line that is still low. A third is a DHI read placed between storing a word and consuming it. The random stimulus skips the consuming read on about a third of the frames, so overruns happen with parity and framing faults in every combination. Faulty stop bits are held low past the stop sample, so each one also tests the receiver's rejection of a false start. A directed step drops the enable in the middle of a frame and then checks that the next frame arrives intact.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DLO  = 2'd2;
  localparam logic [1:0] A_DHI  = 2'd3;

  localparam int unsigned MAX_BITS = 9;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                perr;
    logic                ferr;
  } rx_frame_t;

  function automatic logic [3:0] len_bits(input logic [1:0] sel);
    case (sel)
      2'b01:   return 4'd7;
      2'b10:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic [3:0] nbits_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam logic [3:0] OS_MID  = 4'd7;
  localparam logic [3:0] OS_LAST = 4'd15;

  rx_state_e            state_q;
  logic [3:0]           os_q;
  logic [3:0]           idx_q;
  logic [MAX_BITS-1:0]  sh_q;
  logic                 perr_q, ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_o  <= 1'b0;
    end else if (!en_i) begin
      state_q <= S_IDLE;
      os_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          S_IDLE: if (!rx_i) begin
            state_q <= S_START;
            os_q    <= '0;
          end
          S_START: begin
            if (os_q == OS_MID) begin
              os_q <= '0;
              if (rx_i) state_q <= S_IDLE;  // noise: line back high at mid-bit
              else begin
                state_q <= S_DATA;
                idx_q   <= '0;
                sh_q    <= '0;
                perr_q  <= 1'b0;
              end
            end else os_q <= os_q + 1'b1;
          end
          S_DATA: begin
            if (os_q == OS_LAST) begin
              os_q        <= '0;
              sh_q[idx_q] <= rx_i;
              idx_q       <= idx_q + 1'b1;
              if (idx_q == nbits_i - 4'd1) state_q <= par_en_i ? S_PAR : S_STOP;
            end else os_q <= os_q + 1'b1;
          end
          S_PAR: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              perr_q  <= rx_i ^ (^sh_q) ^ par_odd_i;
              state_q <= S_STOP;
            end else os_q <= os_q + 1'b1;
          end
          S_STOP: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              ferr_q  <= ~rx_i;
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else os_q <= os_q + 1'b1;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign frame_o = '{data: sh_q, perr: perr_q, ferr: ferr_q};

  p_idle_when_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == S_IDLE && !done_o));
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [5:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       done_i,
  input  rx_frame_t  frame_i,
  output logic       rx_en_o,
  output logic [3:0] nbits_o,
  output logic       par_en_o,
  output logic       par_odd_o,
  output logic       rxi_o,
  output logic       eri_o,
  output logic       rts_no
);
  logic [5:0]          ctrl_q;
  logic                ovr_q, per_q, fer_q, full_q;
  logic [MAX_BITS-1:0] data_q;
  logic                ovr_d, per_d, fer_d, full_d, rxi_d, eri_d;
  logic [MAX_BITS-1:0] data_d;
  logic                int_en, consume, wr_stat, frame_err;

  assign rx_en_o   = ctrl_q[0];
  assign int_en    = ctrl_q[1];
  assign nbits_o   = len_bits(ctrl_q[3:2]);
  assign par_en_o  = ctrl_q[4];
  assign par_odd_o = ctrl_q[5];

  assign consume   = reg_rd_i && (reg_addr_i == A_DLO);
  assign wr_stat   = reg_wr_i && (reg_addr_i == A_STAT);
  assign frame_err = frame_i.perr | frame_i.ferr;

  always_comb begin
    ovr_d  = ovr_q & ~(wr_stat & ~reg_wdata_i[0]);
    per_d  = per_q & ~(wr_stat & ~reg_wdata_i[1]);
    fer_d  = fer_q & ~(wr_stat & ~reg_wdata_i[2]);
    full_d = full_q & ~consume;
    data_d = data_q;
    rxi_d  = 1'b0;
    eri_d  = 1'b0;
    if (done_i) begin
      if (full_d) begin
        ovr_d = 1'b1;  // keep unread word
        eri_d = int_en;
      end else begin
        data_d = frame_i.data;
        full_d = 1'b1;
        per_d  = per_d | frame_i.perr;
        fer_d  = fer_d | frame_i.ferr;
        rxi_d  = ~frame_err;
        eri_d  = frame_err & int_en;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
      per_q  <= 1'b0;
      fer_q  <= 1'b0;
      full_q <= 1'b0;
      data_q <= '0;
      rxi_o  <= 1'b0;
      eri_o  <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == A_CTRL) ctrl_q <= reg_wdata_i;
      ovr_q  <= ovr_d;
      per_q  <= per_d;
      fer_q  <= fer_d;
      full_q <= full_d;
      data_q <= data_d;
      rxi_o  <= rxi_d;
      eri_o  <= eri_d;
    end
  end

  assign rts_no = ~(rx_en_o & ~full_q);

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {2'b00, ctrl_q};
      A_STAT:  reg_rdata_o = {5'b0, fer_q, per_q, ovr_q};
      A_DLO:   reg_rdata_o = data_q[7:0];
      default: reg_rdata_o = {7'b0, data_q[8]};
    endcase
  end

  p_ovr_keeps_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_q && !consume) |=> ($stable(data_q) && ovr_q && !rxi_o));
  p_hi_read_no_consume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_DHI && full_q) |=> full_q);
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fer_q || per_q) && !reg_wr_i) |=> ($past(fer_q) -> fer_q) && ($past(per_q) -> per_q));
  p_eri_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eri_o |-> $past(int_en));
  p_rts_after_store_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !full_q) |=> rts_no);
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [5:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       rxi_o,
  output logic       eri_o,
  output logic       rts_no
);
  logic [1:0] rx_sync_q;
  logic       tick, done, rx_en, par_en, par_odd;
  logic [3:0] nbits;
  rx_frame_t  frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_sync_q <= 2'b11;
    else         rx_sync_q <= {rx_sync_q[0], rx_i};
  end

  uart_baud_gen #(.DIV(OVS_DIV)) i_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en),
    .tick_o(tick)
  );

  uart_rx_frame i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en),
    .tick_i   (tick),
    .rx_i     (rx_sync_q[1]),
    .nbits_i  (nbits),
    .par_en_i (par_en),
    .par_odd_i(par_odd),
    .done_o   (done),
    .frame_o  (frame)
  );

  uart_rx_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .done_i     (done),
    .frame_i    (frame),
    .rx_en_o    (rx_en),
    .nbits_o    (nbits),
    .par_en_o   (par_en),
    .par_odd_o  (par_odd),
    .rxi_o      (rxi_o),
    .eri_o      (eri_o),
    .rts_no     (rts_no)
  );
endmodule

// File: tb/test_uart_rx_fc.sv
module test_uart_rx_fc;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int BITC  = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [5:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxi, eri, rts_n;

  uart_rx_fc #(.OVS_DIV(DIV)) i_uart_rx_fc (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rxi_o(rxi), .eri_o(eri), .rts_no(rts_n)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, rxi_cnt = 0, eri_cnt = 0;

  always @(negedge clk) begin
    if (rxi) rxi_cnt++;
    if (eri) eri_cnt++;
  end

  // model state
  bit       m_full, m_ovr, m_per, m_fer, m_en, m_ie, m_pe, m_odd;
  int       m_n;
  bit [8:0] m_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [1:0] len_code(input int n);
    return (n == 7) ? 2'b01 : (n == 9) ? 2'b10 : 2'b00;
  endfunction

  function automatic bit [8:0] mask_n(input bit [8:0] d, input int n);
    return d & ((9'h1 << n) - 9'h1);
  endfunction

  function automatic bit [7:0] stat_exp();
    return {5'b0, m_fer, m_per, m_ovr};
  endfunction

  task automatic set_ctrl(input bit en, input bit ie, input int n, input bit pe, input bit odd);
    m_en = en; m_ie = ie; m_n = n; m_pe = pe; m_odd = odd;
    reg_wr(2'd0, {odd, pe, len_code(n), ie, en});
  endtask

  task automatic wait_bits(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic send(input bit [8:0] d, input bit bad_par, input bit bad_stop);
    bit [8:0] md;
    md = mask_n(d, m_n);
    @(negedge clk); rx = 1'b0; wait_bits(BITC);
    for (int i = 0; i < m_n; i++) begin rx = md[i]; wait_bits(BITC); end
    if (m_pe) begin rx = (^md) ^ m_odd ^ bad_par; wait_bits(BITC); end
    if (bad_stop) begin rx = 1'b0; wait_bits(12*DIV); rx = 1'b1; wait_bits(4*DIV); end
    else begin rx = 1'b1; wait_bits(BITC); end
    wait_bits(2*BITC);
  endtask

  // send a frame and check pulses, flags and flow control against the model
  task automatic frame_check(input bit [8:0] d, input bit bad_par, input bit bad_stop);
    int r0, e0;
    bit err, e_rxi, e_eri;
    logic [7:0] v;
    r0 = rxi_cnt; e0 = eri_cnt;
    send(d, bad_par, bad_stop);
    err = (m_pe && bad_par) || bad_stop;
    if (m_full) begin
      m_ovr = 1'b1; e_rxi = 1'b0; e_eri = m_ie;
    end else begin
      m_data = mask_n(d, m_n); m_full = 1'b1;
      m_per |= m_pe && bad_par; m_fer |= bad_stop;
      e_rxi = !err; e_eri = err && m_ie;
    end
    chk("R7 rxi pulse", rxi_cnt - r0, e_rxi);
    chk("R8 eri pulse", eri_cnt - e0, e_eri);
    chk("R12 rts high while held", rts_n, 1'b1);
    reg_rd(2'd1, v);
    chk("R4 R5 R6 stat", v, stat_exp());
  endtask

  task automatic consume_check();
    logic [7:0] v;
    reg_rd(2'd3, v);
    chk("R3 data hi", v, {7'b0, m_data[8]});
    chk("R9 rts after hi read", rts_n, 1'b1);
    reg_rd(2'd2, v);
    chk("R3 data lo", v, m_data[7:0]);
    m_full = 1'b0;
    chk("R9 rts after lo read", rts_n, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int r0, e0;
    void'($urandom(32'h1357));
    m_full = 0; m_ovr = 0; m_per = 0; m_fer = 0; m_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rts after reset", rts_n, 1'b1);
    reg_rd(2'd1, v);
    chk("R1 stat after reset", v, 8'h00);

    set_ctrl(1, 1, 8, 0, 0);
    chk("R1 rts low on enable", rts_n, 1'b0);

    // R2: short low glitch
    r0 = rxi_cnt; e0 = eri_cnt;
    @(negedge clk); rx = 1'b0; wait_bits(3*DIV); rx = 1'b1; wait_bits(2*BITC);
    chk("R2 glitch no rxi", rxi_cnt - r0, 0);
    chk("R2 glitch no eri", eri_cnt - e0, 0);
    chk("R2 rts unchanged", rts_n, 1'b0);

    // directed clean 8-bit frame
    frame_check(9'h0A5, 0, 0);
    consume_check();

    // R6: overrun keeps first word
    frame_check(9'h03C, 0, 0);
    frame_check(9'h0C3, 0, 0);
    consume_check();

    // R10: write 1 keeps, write 0 clears
    reg_wr(2'd1, 6'h07);
    reg_rd(2'd1, v);
    chk("R10 write ones keeps flags", v, stat_exp());
    reg_wr(2'd1, 6'h06);
    m_ovr = 0;
    reg_rd(2'd1, v);
    chk("R10 write zero clears ovr", v, stat_exp());

    // R8: errors with interrupts disabled
    set_ctrl(1, 0, 8, 1, 1);
    frame_check(9'h055, 1, 0);
    frame_check(9'h066, 0, 1);
    consume_check();
    reg_wr(2'd1, 6'h00);
    m_ovr = 0; m_per = 0; m_fer = 0;

    // R11: abort mid-frame
    set_ctrl(1, 1, 9, 1, 0);
    r0 = rxi_cnt; e0 = eri_cnt;
    @(negedge clk); rx = 1'b0; wait_bits(3*BITC);
    reg_wr(2'd0, {m_odd, m_pe, len_code(m_n), m_ie, 1'b0});
    chk("R11 rts high when disabled", rts_n, 1'b1);
    rx = 1'b1; wait_bits(2*BITC);
    reg_wr(2'd0, {m_odd, m_pe, len_code(m_n), m_ie, 1'b1});
    wait_bits(BITC);
    chk("R11 no pulse after abort", (rxi_cnt - r0) + (eri_cnt - e0), 0);
    chk("R11 rts low on re-enable", rts_n, 1'b0);
    frame_check(9'h1A7, 0, 0);
    consume_check();

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit [8:0] d;
      bit bp, bs;
      if (k % 6 == 0) begin
        int n;
        n = 7 + int'($urandom % 3);
        set_ctrl(1, $urandom % 4 != 0, n, $urandom % 2, $urandom % 2);
      end
      d  = 9'($urandom);
      bp = ($urandom % 5 == 0);
      bs = ($urandom % 6 == 0);
      frame_check(d, bp, bs);
      if ($urandom % 3 != 0) consume_check();
      if ($urandom % 4 == 0) begin
        reg_wr(2'd1, 6'h00);
        m_ovr = 0; m_per = 0; m_fer = 0;
        reg_rd(2'd1, v);
        chk("R10 clear all", v, 8'h00);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule